// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two signed two's-complement operands of `W` bits each and returns a signed product of `2W` bits. The operands are sampled on a start pulse. Each one is reduced to its unsigned magnitude, and the two magnitudes are multiplied by an iterative shift-and-add loop that takes one multiplier bit per clock, lowest bit first. Once the loop has run its `W` steps, the product is negated if the operand signs differed.

A single `2W`-bit register holds both the growing product and the multiplier bits that remain. Each step adds either the multiplicand or zero to the upper half of this register, then shifts the whole register right by one place. Low product bits that are complete move into the lower half, and no later addition touches them. A short start/busy/done handshake frames each operation. The output register is written only when done is raised, so the result stays readable while the next operation runs.

Top module: `smul_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are low and product is zero until a first result is produced.
- R2: A start pulse seen while busy is low is accepted at that clock edge, and busy is high in the following cycle.
- R3: done is high for exactly one cycle, and it rises on the W+1th clock edge after the edge that accepted start.
- R4: busy stays high for exactly W+1 cycles and is low in the cycle where done is high.
- R5: A start pulse, and any operand values, applied while busy is high are ignored: the result, the timing and the number of done pulses of the running operation do not change.
- R6: In the done cycle, product equals the two's-complement product of the two operands sampled at the accepted start, interpreted as signed W-bit values and given as a signed 2W-bit value.
- R7: The most negative operand value (-2^(W-1)) is handled in either operand or both. For W=8, -128 x -128 = 16384 and -128 x 127 = -16256.
- R8: product changes only at the edge that raises done. Between results, including while the next operation is busy, it holds its previous value.
- R9: A zero operand combined with a negative one gives a product of exactly zero.
- R10: A start applied in the cycle where done is high is accepted, so operations can follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication; honoured only while busy is low |
| mcand | input | W | Signed multiplicand, sampled when start is accepted |
| mplier | input | W | Signed multiplier, sampled when start is accepted |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse marking a new result on product |
| product | output | 2W | Signed product, held between results |

## Verification
The hardest case to create from the ports is a start request that arrives while an operation is still running. It must leave the result, the latency and the count of done pulses unchanged, and it is only visible if the stray operands differ from the real ones. The bench therefore raises start in the middle of busy windows with altered operand values. It then confirms that the scoreboard still sees a single result equal to the original pair's product, on the expected cycle. Back-to-back starts issued in the done cycle, together with exhaustive operand pairs at W=4 (including both most negative values), cover sign fix-up at the range edges. Product stability is checked during the following busy window.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } smul_state_e;
endpackage

// File: rtl/smul_mag.sv
// Two's-complement magnitude of one operand. The output is unsigned and W bits
// wide, so the most negative input maps to 2^(W-1) without overflow.
module smul_mag #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = val[W-1];
    mag = neg ? (~val + {{(W-1){1'b0}}, 1'b1}) : val;
  end
endmodule

// File: rtl/smul_ctrl.sv
// Sequencer: idle, W shift-add steps, one sign fix-up cycle.
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic fix,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  smul_state_e    state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    fix     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
      end
      ST_FIX: begin
        fix     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = fix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/smul_core.sv
// Combined product/multiplier register. The upper half accumulates, and the lower
// half holds the unused multiplier bits plus the finished low product bits.
module smul_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_mag,
  input  logic [W-1:0]   mplier_mag,
  input  logic           sign_in,
  output logic [2*W-1:0] raw,
  output logic           sign_q
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q, mcand_d;
  logic [PW-1:0] acc_q, acc_d;
  logic          sign_d;
  logic [W-1:0]  partial;
  logic [W:0]    sum;

  always_comb begin
    partial = acc_q[0] ? mcand_q : '0;
    sum     = {1'b0, acc_q[PW-1:W]} + {1'b0, partial};
    mcand_d = mcand_q;
    acc_d   = acc_q;
    sign_d  = sign_q;
    if (load) begin
      mcand_d = mcand_mag;
      acc_d   = {{W{1'b0}}, mplier_mag};
      sign_d  = sign_in;
    end else if (step) begin
      acc_d = {sum, acc_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
      sign_q  <= 1'b0;
    end else begin
      mcand_q <= mcand_d;
      acc_q   <= acc_d;
      sign_q  <= sign_d;
    end
  end

  assign raw = acc_q;
endmodule

// File: rtl/smul_fix.sv
// Output register with the final conditional negation.
module smul_fix #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fix,
  input  logic           neg,
  input  logic [2*W-1:0] raw,
  output logic [2*W-1:0] result
);
  logic [2*W-1:0] result_q, result_d;

  always_comb begin
    result_d = result_q;
    if (fix) result_d = neg ? (~raw + {{(2*W-1){1'b0}}, 1'b1}) : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end

  assign result = result_q;
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][W-1:0] op_val, op_mag;
  logic [NOPS-1:0]        op_neg;
  logic                   load, step, fix, sign_q;
  logic [2*W-1:0]         raw;

  assign op_val[0] = mcand;
  assign op_val[1] = mplier;

  for (genvar i = 0; i < NOPS; i++) begin : g_mag
    smul_mag #(.W(W)) u_mag (
      .val (op_val[i]),
      .mag (op_mag[i]),
      .neg (op_neg[i])
    );
  end

  smul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .fix   (fix),
    .busy  (busy),
    .done  (done)
  );

  smul_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .mcand_mag  (op_mag[0]),
    .mplier_mag (op_mag[1]),
    .sign_in    (op_neg[0] ^ op_neg[1]),
    .raw        (raw),
    .sign_q     (sign_q)
  );

  smul_fix #(.W(W)) u_fix (
    .clk    (clk),
    .rst_n  (rst_n),
    .fix    (fix),
    .neg    (sign_q),
    .raw    (raw),
    .result (product)
  );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 2) + 1;

  logic [W-1:0]          a_q, b_q;
  logic [CW-1:0]         bcnt;
  logic signed [2*W-1:0] ea, eb, expv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      bcnt <= '0;
    end else begin
      if (start && !busy) begin
        a_q <= mcand;
        b_q <= mplier;
      end
      bcnt <= busy ? bcnt + 1'b1 : '0;
    end
  end

  always_comb begin
    ea   = {{W{a_q[W-1]}}, a_q};
    eb   = {{W{b_q[W-1]}}, b_q};
    expv = ea * eb;
  end

  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == CW'(W + 1)));

  a_r4_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_product_value: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == expv));

  a_r8_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
endmodule

bind smul_seq smul_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/tb_smul_seq.sv
module tb_smul_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 8;
  localparam int WB = 4;

  logic clk, rst_n;
  logic st_a, busy_a, done_a;
  logic [WA-1:0]   a_a, b_a;
  logic [2*WA-1:0] p_a;
  logic st_b, busy_b, done_b;
  logic [WB-1:0]   a_b, b_b;
  logic [2*WB-1:0] p_b;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [2*WA-1:0] qa[$];
  string           ta[$];
  logic [2*WB-1:0] qb[$];
  string           tb_q[$];

  smul_seq #(.W(WA)) dut (
    .clk(clk), .rst_n(rst_n), .start(st_a), .mcand(a_a), .mplier(b_a),
    .busy(busy_a), .done(done_a), .product(p_a)
  );

  smul_seq #(.W(WB)) dut_n4 (
    .clk(clk), .rst_n(rst_n), .start(st_b), .mcand(a_b), .mplier(b_b),
    .busy(busy_b), .done(done_b), .product(p_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [2*WA-1:0] ref_a(input logic [WA-1:0] x, input logic [WA-1:0] y);
    int xi, yi;
    xi = $signed(x);
    yi = $signed(y);
    return (2*WA)'(xi * yi);
  endfunction

  function automatic logic [2*WB-1:0] ref_b(input logic [WB-1:0] x, input logic [WB-1:0] y);
    int xi, yi;
    xi = $signed(x);
    yi = $signed(y);
    return (2*WB)'(xi * yi);
  endfunction

  // Scoreboard monitors: pop the expected item when a done pulse appears.
  always @(negedge clk) begin
    if (rst_n && done_a) begin
      if (qa.size() == 0) check(1'b0, "R5", "unexpected done W=8", 1, 0);
      else begin
        logic [2*WA-1:0] e;
        string t;
        e = qa.pop_front();
        t = ta.pop_front();
        check(p_a == e, t, "product W=8", $signed(p_a), $signed(e));
      end
    end
    if (rst_n && done_b) begin
      if (qb.size() == 0) check(1'b0, "R5", "unexpected done W=4", 1, 0);
      else begin
        logic [2*WB-1:0] e;
        string t;
        e = qb.pop_front();
        t = tb_q.pop_front();
        check(p_b == e, t, "product W=4", $signed(p_b), $signed(e));
      end
    end
  end

  // Driver for the W=8 instance. b2b drives start in the current (done) cycle,
  // and inject raises a stray start with other operands while busy.
  task automatic run_a(input logic [WA-1:0] x, input logic [WA-1:0] y,
                       input string tag, input bit b2b, input bit inject);
    int cyc;
    logic [2*WA-1:0] held;
    if (!b2b) @(negedge clk);
    a_a = x; b_a = y; st_a = 1'b1;
    qa.push_back(ref_a(x, y));
    ta.push_back(tag);
    held = p_a;
    @(negedge clk);
    st_a = 1'b0;
    cyc = 1;
    check(busy_a == 1'b1, "R2", "busy after start", busy_a, 1);
    while (!done_a && cyc < 100) begin
      check(p_a == held, "R8", "product held while busy", p_a, held);
      if (inject && cyc == 2) begin
        st_a = 1'b1; a_a = ~x; b_a = y + 8'd3;
      end else begin
        st_a = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    st_a = 1'b0;
    check(cyc == WA + 2, inject ? "R5" : "R3", "done latency", cyc, WA + 2);
    check(busy_a == 1'b0, "R4", "busy low on done", busy_a, 0);
  endtask

  task automatic run_b(input logic [WB-1:0] x, input logic [WB-1:0] y, input string tag);
    int cyc;
    @(negedge clk);
    a_b = x; b_b = y; st_b = 1'b1;
    qb.push_back(ref_b(x, y));
    tb_q.push_back(tag);
    @(negedge clk);
    st_b = 1'b0;
    cyc = 1;
    while (!done_b && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == WB + 2, "R3", "done latency W=4", cyc, WB + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    st_a = 1'b0; a_a = '0; b_a = '0;
    st_b = 1'b0; a_b = '0; b_b = '0;
    repeat (3) @(negedge clk);
    check(busy_a == 0 && done_a == 0, "R1", "busy/done in reset", {busy_a, done_a}, 0);
    check(p_a == 0, "R1", "product in reset", p_a, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_a == 0 && done_a == 0 && p_a == 0, "R1", "idle after reset",
          {busy_a, done_a}, 0);

    // Basic patterns
    run_a(8'd14, 8'd13, "R6", 0, 0);
    run_a(8'd40, 8'd25, "R6", 0, 0);
    run_a(8'hF3, 8'd11, "R6", 0, 0);
    run_a(8'd9, 8'hF9, "R6", 0, 0);
    run_a(8'hFF, 8'hFF, "R6", 0, 0);
    // Range corners
    run_a(8'h80, 8'h80, "R7", 0, 0);
    run_a(8'h80, 8'h7F, "R7", 0, 0);
    run_a(8'h7F, 8'h80, "R7", 0, 0);
    run_a(8'h80, 8'h01, "R7", 0, 0);
    run_a(8'h7F, 8'h7F, "R7", 0, 0);
    // Zero with negative operands
    run_a(8'h00, 8'hFB, "R9", 0, 0);
    run_a(8'hFB, 8'h00, "R9", 0, 0);
    run_a(8'h80, 8'h00, "R9", 0, 0);
    // Stray start while busy
    run_a(8'd37, 8'hE1, "R5", 0, 1);
    run_a(8'h80, 8'h81, "R5", 0, 1);
    // Back-to-back starts in the done cycle
    run_a(8'd5, 8'd6, "R10", 0, 0);
    run_a(8'hF0, 8'd7, "R10", 1, 0);
    run_a(8'd100, 8'h9C, "R10", 1, 0);
    // Idle gap: product must hold
    repeat (4) @(negedge clk);
    check(p_a == ref_a(8'd100, 8'h9C), "R8", "product held idle", p_a, ref_a(8'd100, 8'h9C));

    for (int i = 0; i < 200; i++) begin
      logic [WA-1:0] x, y;
      x = WA'($urandom);
      y = WA'($urandom);
      run_a(x, y, "R6", (i % 7) == 3, (i % 11) == 5);
    end

    for (int i = 0; i < (1 << WB); i++) begin
      for (int j = 0; j < (1 << WB); j++) begin
        run_b(WB'(i), WB'(j), (i == 8 || j == 8) ? "R7" : "R6");
      end
    end

    repeat (3) @(negedge clk);
    check(qa.size() == 0, "R3", "missing done W=8", qa.size(), 0);
    check(qb.size() == 0, "R3", "missing done W=4", qb.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule